// File: doc/BRIEF.md
# Serial Receive Deserialiser with Frame Hunt

This block sits behind a clock and data recovery stage and runs entirely on the recovered serial clock. Each serial bit is first qualified by a pair of signal-detect inputs. Only when exactly one of them is high does the bit pass unchanged; otherwise the stream is forced to zero. The qualified bits are then packed into parallel words of 4 or 8 bits. The block also produces a one-cycle word strobe that serves as the derived parallel clock enable.

Word alignment can be re-established by a frame hunt. A rising edge on the asynchronous out-of-frame input arms the hunt, after that input has been synchronised. While the hunt is armed, every detection of the framing sequence realigns the word counter, so the first bit after the sequence starts a new word. The first complete word after such a boundary is flagged by a frame pulse. The hunt disarms only once a boundary has been found and the out-of-frame input has dropped. From then on, the alignment is locked and further framing sequences have no effect.

The hunt controller has three states:
- `HS_LOCKED`: the hunt is disarmed and the alignment is fixed.
- `HS_SEARCH`: the hunt is armed and no boundary has been found yet.
- `HS_CONFIRM`: the hunt is armed, a boundary has been found, and the block waits for the out-of-frame input to fall.

Its transitions are:
- LOCKED→SEARCH on a synchronised rising edge of the out-of-frame input.
- SEARCH→CONFIRM on a match while the synchronised out-of-frame level is high.
- SEARCH→LOCKED on a match while that level is low.
- CONFIRM→LOCKED when that level is low.
- CONFIRM stays in CONFIRM on a match and realigns.

Top module: `rxdes_top`

## Requirements
- R1: The serial bit is used as received when `sd_a` XOR `sd_b` is 1. When both are 0 or both are 1, the bit is replaced by 0.
- R2: `oof_in` passes through two synchroniser flops. A 0→1 change seen at the synchroniser output while the controller is in HS_LOCKED moves it to HS_SEARCH at the next clock edge.
- R3: In HS_LOCKED, a framing sequence in the stream causes no realignment and no frame pulse.
- R4: The framing sequence is the bytes F6, F6, F6, 28, 28, 28 in that order, each byte received most significant bit first.
- R5: When the last bit of the framing sequence has been received while the hunt is armed, the next received bit becomes the first (most significant) bit of a new word.
- R6: `frame_pulse` is high for exactly one cycle. It is high together with `par_valid` for the first complete word after a realignment.
- R7: The hunt stays armed after a boundary is found for as long as the synchronised out-of-frame level is high, and each further match realigns again. If the level is already low when a match occurs in HS_SEARCH, the hunt disarms at once. A level that falls before any match does not disarm it.
- R8: When `wide_sel`=1, a word is 8 bits and `par_valid` pulses every 8 bits. When `wide_sel`=0, a word is 4 bits, placed in `par_word[3:0]` with `par_word[7:4]`=0, and `par_valid` pulses every 4 bits.
- R9: `par_valid` is a single-cycle pulse per word. The earliest received bit of the word is in its most significant position, and `par_word` holds its value between pulses.
- R10: If a realignment falls in the same cycle in which a word would complete, the realignment wins. The partial word is dropped and no strobe is produced in that cycle.
- R11: After reset, `par_word`=0, `par_valid`=0, `frame_pulse`=0, the controller is in HS_LOCKED, and the first word completes after a full word of bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Recovered serial clock, master clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Recovered serial data bit |
| sd_a | input | 1 | Signal-detect input A |
| sd_b | input | 1 | Signal-detect input B |
| oof_in | input | 1 | Asynchronous out-of-frame request; a rising edge arms the hunt |
| wide_sel | input | 1 | Word width select: 1 = 8-bit, 0 = 4-bit |
| par_word | output | 8 | Last completed parallel word |
| par_valid | output | 1 | One-cycle strobe per completed word (parallel clock enable) |
| frame_pulse | output | 1 | One-cycle marker on the first word after a frame boundary |

## Verification
Realignment and word completion can fall in the same clock cycle. The bench provokes this by holding the hunt armed and preceding a framing sequence with every offset from 0 to 7 filler bits. The end of the sequence therefore lands on each possible position of the running word counter, including its final bit. A reference model in the bench gives realignment priority and drops the partial word. Strobe, frame marker and word are compared with that model on every clock. A second pairing is also exercised: a match arriving while the synchronised out-of-frame level is already low, which must disarm the hunt in the same step.

// File: rtl/rxdes_pkg.sv
package rxdes_pkg;

    localparam int WORD_MAX   = 8;
    localparam int WORD_MIN   = 4;
    localparam int CNT_W      = $clog2(WORD_MAX) + 1;
    localparam int A_REPEAT   = 3;
    localparam int B_REPEAT   = 3;
    localparam logic [7:0] A_BYTE = 8'hF6;
    localparam logic [7:0] B_BYTE = 8'h28;
    localparam int PAT_BYTES  = A_REPEAT + B_REPEAT;
    localparam int PAT_W      = PAT_BYTES * 8;

    typedef enum logic [1:0] {
        HS_LOCKED  = 2'd0,
        HS_SEARCH  = 2'd1,
        HS_CONFIRM = 2'd2
    } hunt_state_t;

    function automatic logic [PAT_W-1:0] build_pattern();
        logic [PAT_W-1:0] p;
        p = '0;
        for (int i = 0; i < PAT_BYTES; i++) begin
            p = {p[PAT_W-9:0], (i < A_REPEAT) ? A_BYTE : B_BYTE};
        end
        return p;
    endfunction

    localparam logic [PAT_W-1:0] FRAME_PAT = build_pattern();

endpackage

// File: rtl/rxdes_oof_sync.sv
module rxdes_oof_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_out,
    output logic rise_out
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_out = chain_q[STAGES-1];
    assign rise_out  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rxdes_pattern_det.sv
module rxdes_pattern_det
    import rxdes_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic match
);
    logic [PAT_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[PAT_W-2:0], bit_in};
    end

    assign match = (hist_q == FRAME_PAT);

endmodule

// File: rtl/rxdes_hunt_fsm.sv
module rxdes_hunt_fsm
    import rxdes_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oof_level,
    input  logic oof_rise,
    input  logic match,
    output logic realign
);
    hunt_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_LOCKED:  if (oof_rise) state_d = HS_SEARCH;
            HS_SEARCH:  if (match) state_d = oof_level ? HS_CONFIRM : HS_LOCKED;
            HS_CONFIRM: if (!oof_level) state_d = HS_LOCKED;
            default:    state_d = HS_LOCKED;
        endcase
    end

    always_comb begin
        realign = 1'b0;
        unique case (state_q)
            HS_LOCKED:  realign = 1'b0;
            HS_SEARCH:  realign = match;
            HS_CONFIRM: realign = match;
            default:    realign = 1'b0;
        endcase
    end

    AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_LOCKED && oof_rise) |=> (state_q == HS_SEARCH)); // R2
    AST_LOCKED_NO_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_LOCKED) |-> !realign); // R3
    AST_CONFIRM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_CONFIRM && !oof_level) |=> (state_q == HS_LOCKED)); // R7
    AST_SEARCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_SEARCH && !match) |=> (state_q == HS_SEARCH)); // R7

endmodule

// File: rtl/rxdes_deser.sv
module rxdes_deser
    import rxdes_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                realign,
    input  logic                wide_sel,
    output logic [WORD_MAX-1:0] word_out,
    output logic                valid_out,
    output logic                frame_out
);
    logic [CNT_W-1:0]    cnt_q;
    logic [WORD_MAX-1:0] asm_q;
    logic                pend_q;
    logic [CNT_W-1:0]    last_idx;
    logic                done;
    logic [WORD_MAX-1:0] full_word;

    assign last_idx  = wide_sel ? CNT_W'(WORD_MAX - 1) : CNT_W'(WORD_MIN - 1);
    assign done      = (cnt_q >= last_idx);
    assign full_word = wide_sel ? {asm_q[WORD_MAX-2:0], bit_in}
                                : {{(WORD_MAX-WORD_MIN){1'b0}}, asm_q[WORD_MIN-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            asm_q     <= '0;
            pend_q    <= 1'b0;
            word_out  <= '0;
            valid_out <= 1'b0;
            frame_out <= 1'b0;
        end else if (realign) begin
            cnt_q     <= CNT_W'(1);
            asm_q     <= {{(WORD_MAX-1){1'b0}}, bit_in};
            pend_q    <= 1'b1;
            valid_out <= 1'b0;
            frame_out <= 1'b0;
        end else if (done) begin
            cnt_q     <= '0;
            asm_q     <= '0;
            pend_q    <= 1'b0;
            word_out  <= full_word;
            valid_out <= 1'b1;
            frame_out <= pend_q;
        end else begin
            cnt_q     <= cnt_q + CNT_W'(1);
            asm_q     <= {asm_q[WORD_MAX-2:0], bit_in};
            valid_out <= 1'b0;
            frame_out <= 1'b0;
        end
    end

    AST_FRAME_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frame_out |-> valid_out); // R6
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_out |=> !frame_out); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> !valid_out); // R9
    AST_REALIGN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !valid_out); // R10
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> $stable(word_out)); // R9

endmodule

// File: rtl/rxdes_top.sv
module rxdes_top
    import rxdes_pkg::*;
(
    input  logic       clk_ser,
    input  logic       rst_n,
    input  logic       ser_in,
    input  logic       sd_a,
    input  logic       sd_b,
    input  logic       oof_in,
    input  logic       wide_sel,
    output logic [7:0] par_word,
    output logic       par_valid,
    output logic       frame_pulse
);
    logic gated_bit;
    logic oof_level;
    logic oof_rise;
    logic match;
    logic realign;

    // Exactly one signal-detect input high lets data through.
    assign gated_bit = ser_in & (sd_a ^ sd_b);

    rxdes_oof_sync #(.STAGES(2)) u_sync (
        .clk       (clk_ser),
        .rst_n     (rst_n),
        .async_in  (oof_in),
        .level_out (oof_level),
        .rise_out  (oof_rise)
    );

    rxdes_pattern_det u_pat (
        .clk    (clk_ser),
        .rst_n  (rst_n),
        .bit_in (gated_bit),
        .match  (match)
    );

    rxdes_hunt_fsm u_fsm (
        .clk       (clk_ser),
        .rst_n     (rst_n),
        .oof_level (oof_level),
        .oof_rise  (oof_rise),
        .match     (match),
        .realign   (realign)
    );

    rxdes_deser u_deser (
        .clk       (clk_ser),
        .rst_n     (rst_n),
        .bit_in    (gated_bit),
        .realign   (realign),
        .wide_sel  (wide_sel),
        .word_out  (par_word),
        .valid_out (par_valid),
        .frame_out (frame_pulse)
    );

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (!wide_sel && !realign && $past(!wide_sel)) |=> (!par_valid || par_word[7:4] == 4'h0)); // R8

endmodule

// File: tb/rxdes_top_tb.sv
module rxdes_top_tb;

    logic       clk_ser = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       sd_a = 1'b0;
    logic       sd_b = 1'b1;
    logic       oof_in = 1'b0;
    logic       wide_sel = 1'b1;
    logic [7:0] par_word;
    logic       par_valid;
    logic       frame_pulse;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "R11";
    bit    finished = 1'b0;

    localparam logic [47:0] PAT = 48'hF6F6F6282828;

    always #4 clk_ser = ~clk_ser;

    rxdes_top u_dut (
        .clk_ser(clk_ser), .rst_n(rst_n), .ser_in(ser_in), .sd_a(sd_a), .sd_b(sd_b),
        .oof_in(oof_in), .wide_sel(wide_sel), .par_word(par_word),
        .par_valid(par_valid), .frame_pulse(frame_pulse)
    );

    // Behavioural reference model
    logic [47:0] m_hist;
    int          m_state;   // 0 locked, 1 search, 2 confirm
    bit          o1, o2, o3;
    bit          m_bits[$];
    bit          m_pend;
    logic [7:0]  m_word;
    bit          m_valid, m_frame;
    int          dut_frames = 0;
    int          nz_words = 0;

    always @(posedge clk_ser) begin
        if (!rst_n) begin
            m_hist = '0; m_state = 0; o1 = 0; o2 = 0; o3 = 0;
            m_bits.delete(); m_pend = 0; m_word = 8'h00; m_valid = 0; m_frame = 0;
        end else begin
            bit d, mt, rise, re;
            int wl, nxt;
            d    = ser_in & (sd_a ^ sd_b);
            mt   = (m_hist == PAT);
            rise = o2 && !o3;
            re   = (m_state != 0) && mt;
            nxt  = m_state;
            if (m_state == 0 && rise) nxt = 1;
            else if (m_state == 1 && mt) nxt = o2 ? 2 : 0;
            else if (m_state == 2 && !o2) nxt = 0;
            m_state = nxt;
            wl = wide_sel ? 8 : 4;
            m_valid = 0; m_frame = 0;
            if (re) begin
                m_bits.delete(); m_bits.push_back(d); m_pend = 1;
            end else if (m_bits.size() + 1 >= wl) begin
                m_bits.push_back(d);
                m_word = 8'h00;
                for (int i = m_bits.size() - wl; i < m_bits.size(); i++)
                    m_word = {m_word[6:0], m_bits[i]};
                m_valid = 1; m_frame = m_pend; m_pend = 0;
                m_bits.delete();
            end else begin
                m_bits.push_back(d);
            end
            m_hist = {m_hist[46:0], d};
            o3 = o2; o2 = o1; o1 = oof_in;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk_ser) begin
        if (rst_n && !finished) begin
            chk(cur_tag, {6'b0, frame_pulse, par_valid, par_word},
                {6'b0, m_frame, m_valid, m_word});
            if (frame_pulse) dut_frames++;
            if (par_valid && par_word != 8'h00) nz_words++;
        end
    end

    task automatic send_bit(bit b);
        @(negedge clk_ser);
        ser_in = b;
    endtask

    task automatic send_rand(int n);
        for (int i = 0; i < n; i++) send_bit(1'($urandom_range(0, 1)));
    endtask

    task automatic send_pat();
        for (int i = 47; i >= 0; i--) send_bit(PAT[i]);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk_ser);
        // R11: reset state
        chk("R11", {6'b0, frame_pulse, par_valid, par_word}, 16'h0000);
        rst_n = 1'b1;
        cur_tag = "R11";
        send_rand(24);

        // R1: gating truth table
        cur_tag = "R1"; sd_a = 1; sd_b = 0; send_rand(40);
        sd_a = 0; sd_b = 0; send_rand(9);
        nz_words = 0;
        cur_tag = "R1"; send_rand(40);
        chk("R1", 16'(nz_words), 16'd0);
        sd_a = 1; sd_b = 1; send_rand(40);
        chk("R1", 16'(nz_words), 16'd0);
        sd_a = 0; sd_b = 1; send_rand(40);

        // R3: pattern ignored while locked
        cur_tag = "R3"; f0 = dut_frames;
        send_rand(3); send_pat(); send_rand(30);
        chk("R3", 16'(dut_frames - f0), 16'd0);

        // R2 R4 R5 R6: arm hunt, find pattern
        cur_tag = "R2"; oof_in = 1; send_rand(6);
        cur_tag = "R5"; f0 = dut_frames;
        send_pat(); send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_rand(28);
        chk("R6", 16'(dut_frames - f0), 16'd1);
        // R7: still armed while oof high, realigns again
        cur_tag = "R7"; f0 = dut_frames;
        send_rand(5); send_pat(); send_rand(20);
        chk("R7", 16'(dut_frames - f0), 16'd1);
        oof_in = 0; send_rand(6);
        f0 = dut_frames; send_rand(2); send_pat(); send_rand(20);
        chk("R7", 16'(dut_frames - f0), 16'd0);
        // R7: short pulse, fall before match keeps search; match disarms
        oof_in = 1; send_rand(2); oof_in = 0; send_rand(10);
        f0 = dut_frames; send_rand(1); send_pat(); send_rand(20);
        chk("R7", 16'(dut_frames - f0), 16'd1);
        f0 = dut_frames; send_pat(); send_rand(20);
        chk("R7", 16'(dut_frames - f0), 16'd0);

        // R8: narrow words with hunt
        cur_tag = "R8"; wide_sel = 0; send_rand(3);
        oof_in = 1; send_rand(6); send_pat(); send_rand(30);
        oof_in = 0; send_rand(30);
        wide_sel = 1; send_rand(20);

        // R10: realign at every counter position
        cur_tag = "R10"; oof_in = 1; send_rand(6);
        for (int off = 0; off < 8; off++) begin
            send_rand(off); send_pat(); send_rand(16);
        end
        wide_sel = 0;
        for (int off = 0; off < 4; off++) begin
            send_rand(off); send_pat(); send_rand(12);
        end
        oof_in = 0; wide_sel = 1;
        cur_tag = "R9"; send_rand(60);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule